// File: doc/BRIEF.md
# Mode-Switched Interrupt Level Router

This block collects five interrupt sources and turns them into a 3-bit processor interrupt priority level. The sources are two peripheral-controller lines, an Ethernet line, a serial line and a non-maskable request. A mode pin picks one of two routing maps at run time. In the legacy map the Ethernet line leaves the priority path and drives a separate auxiliary interrupt line. That line is meant to feed an expansion-slot interrupt input of the second peripheral controller.

Each source keeps the level it was given when it rose. It holds that pending bit until the source drops, so a mode change only affects later rising edges. A push-button NMI request starts a hold counter, and the NMI source stays active for a parameterised number of clock cycles. The level output reports the highest pending level and is registered. All inputs pass through two-flop synchronisers.

Top module: `irq_level_router`

## Requirements
- R1: Every input passes through a two-flop synchroniser. `ipl_o` and `aux_irq_o` show a change of a source or mode input on the fourth rising clock edge after the input changes, and not earlier.
- R2: While `rst` is high on a clock edge, the following are cleared: the synchronisers, the mode (to 0, alternate map), all pending bits and the NMI hold counter. After reset, `ipl_o` and `aux_irq_o` are 0, and a hold that was running before reset does not reassert the NMI.
- R3: With the mode at 0 (alternate map), the sources take these levels: peripheral 1 to level 6, peripheral 2 to level 2, Ethernet to level 3, serial to level 4, NMI to level 7.
- R4: With the mode at 1 (legacy map), the sources take these levels: peripheral 1 to level 1, peripheral 2 to level 2, serial to level 4, NMI to level 7.
- R5: When the Ethernet line rises while the mode is 1, it sets no pending bit, and `aux_irq_o` follows the Ethernet line. When it rises while the mode is 0, `aux_irq_o` stays 0.
- R6: `ipl_o` is the highest level among the pending bits, and 0 when no bit is pending. No source ever produces level 0.
- R7: A source latches its level on its rising edge and keeps it until it drops, even if the mode changes in between.
- R8: A rising edge on `nmi_btn_i` makes the NMI source active for `HOLD_CYCLES` clock cycles. A new rising edge during the hold reloads the full count.
- R9: A source that drops clears its pending bit, so its level leaves `ipl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| per1_irq_i | input | 1 | First peripheral-controller interrupt, level-sensitive |
| per2_irq_i | input | 1 | Second peripheral-controller interrupt, level-sensitive |
| eth_irq_i | input | 1 | Ethernet interrupt, level-sensitive |
| ser_irq_i | input | 1 | Serial interrupt, level-sensitive |
| nmi_btn_i | input | 1 | NMI push-button request, rising edge starts the hold |
| legacy_mode_i | input | 1 | 0 selects the alternate map, 1 the legacy map |
| ipl_o | output | 3 | Registered processor interrupt priority level |
| aux_irq_o | output | 1 | Registered auxiliary interrupt (Ethernet in legacy map) |

## Verification
A source can rise in the same cycle that the mode pin flips. Because both pass through synchronisers of equal depth, the level captured on that edge must come from the new map. The random phase changes the mode and all four level sources together in one drive. A bench model then latches each source's level on its own rising edges and predicts both outputs. A second collision is an NMI retrigger that lands while an earlier hold is still counting. The check there is that level 7 outlasts the first hold window.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_SRC = 5;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 7;

  localparam int SRC_PER1 = 0;
  localparam int SRC_PER2 = 1;
  localparam int SRC_ETH  = 2;
  localparam int SRC_SER  = 3;
  localparam int SRC_NMI  = 4;

  // Target code 0 means "auxiliary line", since no source may produce level 0.
  localparam logic [LVL_W-1:0] TGT_AUX = '0;

  function automatic logic [LVL_W-1:0] route_level(input int src, input logic legacy);
    logic [LVL_W-1:0] lvl;
    case (src)
      SRC_PER1: lvl = legacy ? 3'd1 : 3'd6;
      SRC_PER2: lvl = 3'd2;
      SRC_ETH:  lvl = legacy ? TGT_AUX : 3'd3;
      SRC_SER:  lvl = 3'd4;
      default:  lvl = 3'd7;
    endcase
    return lvl;
  endfunction

  function automatic logic [LVL_W-1:0] top_level(input logic [NUM_LVL-1:0] pend);
    logic [LVL_W-1:0] lvl;
    lvl = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (pend[i]) lvl = LVL_W'(i + 1);
    end
    return lvl;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_hold.sv
module nmi_hold #(
  parameter int HOLD_CYCLES = 5_000_000,
  localparam int CW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  output logic          active_o,
  output logic [CW-1:0] left_o
);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYCLES);

  logic          req_prev_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      req_prev_q <= req_i;
      if (req_i && !req_prev_q) cnt_q <= HOLD_V;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active_o = (cnt_q != '0);
  assign left_o   = cnt_q;
endmodule

// File: rtl/irq_src_slot.sv
module irq_src_slot #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_i,
  input  logic [LVL_W-1:0] map_lvl_i,
  output logic [LVL_W-1:0] tgt_o
);
  logic             act_prev_q;
  logic [LVL_W-1:0] tgt_q;
  logic             rise;

  assign rise  = act_i && !act_prev_q;
  assign tgt_o = rise ? map_lvl_i : tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_prev_q <= 1'b0;
      tgt_q      <= '0;
    end else begin
      act_prev_q <= act_i;
      if (rise) tgt_q <= map_lvl_i;
    end
  end
endmodule

// File: rtl/irq_level_router.sv
module irq_level_router
  import irq_router_pkg::*;
#(
  parameter int HOLD_CYCLES = 5_000_000,
  localparam int CW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       per1_irq_i,
  input  logic       per2_irq_i,
  input  logic       eth_irq_i,
  input  logic       ser_irq_i,
  input  logic       nmi_btn_i,
  input  logic       legacy_mode_i,
  output logic [2:0] ipl_o,
  output logic       aux_irq_o
);
  localparam int SYNC_W = NUM_SRC + 1;

  logic [SYNC_W-1:0]  raw_in, sync_in;
  logic               mode_s, nmi_req_s, nmi_act;
  logic [CW-1:0]      nmi_left;
  logic [NUM_SRC-1:0] src_act;
  logic [LVL_W-1:0]   src_tgt [NUM_SRC];
  logic [NUM_LVL-1:0] pend_next, pend_q;
  logic               aux_next, aux_pend_q;
  logic [LVL_W-1:0]   ipl_q;
  logic               aux_q;

  assign raw_in = {legacy_mode_i, nmi_btn_i, ser_irq_i, eth_irq_i, per2_irq_i, per1_irq_i};

  irq_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(sync_in)
  );

  assign nmi_req_s = sync_in[4];
  assign mode_s    = sync_in[5];

  nmi_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_nmi (
    .clk(clk), .rst(rst), .req_i(nmi_req_s), .active_o(nmi_act), .left_o(nmi_left)
  );

  assign src_act = {nmi_act, sync_in[3:0]};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
    irq_src_slot #(.LVL_W(LVL_W)) u_slot (
      .clk(clk), .rst(rst), .act_i(src_act[g]),
      .map_lvl_i(route_level(g, mode_s)), .tgt_o(src_tgt[g])
    );
  end

  always_comb begin
    pend_next = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_act[s] && src_tgt[s] != TGT_AUX) pend_next[int'(src_tgt[s]) - 1] = 1'b1;
    end
    aux_next = src_act[SRC_ETH] && (src_tgt[SRC_ETH] == TGT_AUX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= '0;
      aux_pend_q <= 1'b0;
      ipl_q      <= '0;
      aux_q      <= 1'b0;
    end else begin
      pend_q     <= pend_next;
      aux_pend_q <= aux_next;
      ipl_q      <= top_level(pend_q);
      aux_q      <= aux_pend_q;
    end
  end

  assign ipl_o     = ipl_q;
  assign aux_irq_o = aux_q;
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker #(
  parameter int HOLD_CYCLES = 5_000_000,
  parameter int CW = 23
) (
  input logic          clk,
  input logic          rst,
  input logic [6:0]    pend_q,
  input logic          aux_pend_q,
  input logic [2:0]    ipl_o,
  input logic          aux_irq_o,
  input logic [CW-1:0] nmi_left
);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYCLES);

  // R2: a reset edge leaves the level output at zero
  p_ipl_cleared_r2: assert property (@(posedge clk) rst |=> (ipl_o == 3'd0));

  // R5: Ethernet routed to the auxiliary line never also holds level 3
  p_aux_excl_r5: assert property (@(posedge clk) disable iff (rst)
    aux_pend_q |-> !pend_q[2]);

  // R6: nothing pending gives level 0
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (pend_q == 7'd0) |=> (ipl_o == 3'd0));

  // R6: a pending NMI always wins
  p_nmi_wins_r6: assert property (@(posedge clk) disable iff (rst)
    pend_q[6] |=> (ipl_o == 3'd7));

  // R8: the hold counter only counts down by one or reloads to the full value
  p_hold_step_r8: assert property (@(posedge clk) disable iff (rst)
    (nmi_left != '0) |=> (nmi_left == $past(nmi_left) - 1'b1) || (nmi_left == HOLD_V));

  // R8: an idle counter stays idle unless reloaded
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (nmi_left == '0) |=> (nmi_left == '0) || (nmi_left == HOLD_V));
endmodule

bind irq_level_router irq_router_checker #(.HOLD_CYCLES(HOLD_CYCLES), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .pend_q(pend_q), .aux_pend_q(aux_pend_q),
  .ipl_o(ipl_o), .aux_irq_o(aux_irq_o), .nmi_left(nmi_left)
);

// File: tb/test_irq_level_router.sv
module test_irq_level_router;
  localparam int HOLD = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic per1 = 0, per2 = 0, eth = 0, ser = 0, nmi = 0, mode = 0;
  logic [2:0] ipl;
  logic aux;
  int n_chk = 0, n_bad = 0;
  bit  done = 0;

  logic       m_prev [4];
  logic [2:0] m_tgt  [4];

  always #10 clk = ~clk;

  irq_level_router #(.HOLD_CYCLES(HOLD)) i_irq_level_router (
    .clk(clk), .rst(rst), .per1_irq_i(per1), .per2_irq_i(per2), .eth_irq_i(eth),
    .ser_irq_i(ser), .nmi_btn_i(nmi), .legacy_mode_i(mode), .ipl_o(ipl), .aux_irq_o(aux)
  );

  function automatic logic [2:0] exp_map(int s, logic legacy);
    case (s)
      0: return legacy ? 3'd1 : 3'd6;
      1: return 3'd2;
      2: return legacy ? 3'd0 : 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(logic p1, logic p2, logic e, logic s, logic m);
    per1 = p1; per2 = p2; eth = e; ser = s; mode = m;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin m_prev[i] = 0; m_tgt[i] = 0; end
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    logic nm;
    logic [3:0] cur;
    int e_ipl, e_aux;
    void'($urandom(32'd1234));
    drive(0, 0, 0, 0, 0);
    do_reset();
    step(1);
    chk("R2 reset ipl", ipl, 0);
    chk("R2 reset aux", aux, 0);

    // R1 latency: fourth edge
    drive(1, 0, 0, 0, 0);
    step(3); chk("R1 before 4th edge", ipl, 0);
    step(1); chk("R1 at 4th edge / R3 per1 alt", ipl, 6);
    drive(0, 0, 0, 0, 0); step(6); chk("R9 drop clears", ipl, 0);

    // R3 alternate map
    drive(0, 1, 0, 0, 0); step(6); chk("R3 per2 alt", ipl, 2);
    drive(0, 0, 1, 0, 0); step(6); chk("R3 eth alt", ipl, 3);
    chk("R5 aux low in alt", aux, 0);
    drive(0, 0, 0, 1, 0); step(6); chk("R3 ser alt", ipl, 4);
    drive(0, 0, 0, 0, 0); step(6);

    // R4 legacy map, R5 aux routing
    drive(0, 0, 0, 0, 1); step(6);
    drive(1, 0, 0, 0, 1); step(6); chk("R4 per1 legacy", ipl, 1);
    drive(0, 1, 0, 0, 1); step(6); chk("R4 per2 legacy", ipl, 2);
    drive(0, 0, 0, 1, 1); step(6); chk("R4 ser legacy", ipl, 4);
    drive(0, 0, 1, 0, 1); step(6); chk("R5 eth legacy ipl", ipl, 0);
    chk("R5 eth legacy aux", aux, 1);
    drive(0, 1, 1, 0, 1); step(6); chk("R5 eth+per2 ipl", ipl, 2);
    drive(0, 1, 0, 0, 1); step(6); chk("R5 aux follows drop", aux, 0);

    // R6 priority
    drive(1, 1, 0, 1, 1); step(6); chk("R6 ser beats per1/per2", ipl, 4);
    drive(0, 0, 0, 0, 0); step(6); chk("R6 idle zero", ipl, 0);

    // R7 latched level across mode change
    drive(1, 0, 0, 0, 0); step(6); chk("R7 per1 alt", ipl, 6);
    drive(1, 0, 0, 0, 1); step(6); chk("R7 held after mode flip", ipl, 6);
    drive(0, 0, 0, 0, 1); step(6); chk("R9 drop after flip", ipl, 0);
    drive(1, 0, 0, 0, 1); step(6); chk("R7 new edge new map", ipl, 1);
    drive(0, 0, 0, 0, 0); step(6);

    // R8 NMI hold
    nmi = 1; step(3); nmi = 0;
    step(HOLD - 1); chk("R8 nmi held", ipl, 7);
    step(6); chk("R8 nmi released", ipl, 0);
    // R8 retrigger
    nmi = 1; step(3); nmi = 0;
    step(HOLD - 13);
    nmi = 1; step(3); nmi = 0;
    step(12); chk("R8 retrigger extends", ipl, 7);
    step(HOLD); chk("R8 retrigger ends", ipl, 0);

    // R2 reset cancels hold
    nmi = 1; step(3); nmi = 0; step(8);
    chk("R2 nmi before reset", ipl, 7);
    do_reset();
    step(1); chk("R2 ipl after reset", ipl, 0);
    step(20); chk("R2 hold cancelled", ipl, 0);

    // Random phase with model
    do_reset();
    for (int k = 0; k < 300; k++) begin
      v = 4'($urandom);
      nm = 1'($urandom);
      drive(v[0], v[1], v[2], v[3], nm);
      cur = v;
      for (int i = 0; i < 4; i++) begin
        if (cur[i] && !m_prev[i]) m_tgt[i] = exp_map(i, nm);
        m_prev[i] = cur[i];
      end
      e_ipl = 0;
      e_aux = 0;
      for (int i = 0; i < 4; i++) begin
        if (cur[i] && m_tgt[i] != 0 && int'(m_tgt[i]) > e_ipl) e_ipl = int'(m_tgt[i]);
      end
      if (cur[2] && m_tgt[2] == 0) e_aux = 1;
      step(5);
      chk("R7 random ipl", ipl, e_ipl);
      chk("R5 random aux", aux, e_aux);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule